// File: doc/BRIEF.md
# Interrupt Set/Clear State Bank

This block holds the per-interrupt state of an interrupt distributor. Each interrupt has four bits: enable, pending, active and trigger mode. It is reached through a small register bus with a byte address, 32-bit write data, an access size, read and write strobes and registered read data. Enable, pending and active each have a pair of windows. Writing ones to the set window raises the addressed bits. Writing ones to the clear window drops them. Trigger mode sits in a configuration window with two bits per interrupt.

Each interrupt also has a level input line. For a level-triggered interrupt, pending follows that line. A separate software-pending latch keeps a pending state that was set by a bus write alive after the line drops. Clearing pending, or switching an interrupt back to level mode, recomputes pending from the line and that latch. The current enable, pending, active and trigger-mode vectors are exported for the arbitration logic that sits downstream.

Address map, relative to the block base:

| Window | Base |
|---|---|
| set enable | 0x000 |
| clear enable | 0x080 |
| set pending | 0x100 |
| clear pending | 0x180 |
| set active | 0x200 |
| clear active | 0x280 |
| configuration | 0x300 |

In the one-bit windows, address bits [6:2] select word W. In the configuration window, address bits [7:2] select word C.

Top module: `irq_state_bank`

## Requirements
- R1: While reset is held, all enable, pending, active and software-pending state is zero, every interrupt is level-triggered and the read data is zero.
- R2: A write to a set window (enable at 0x000, pending at 0x100, active at 0x200) sets the state bit of interrupt 32*W+b for every data bit b written as 1. Bits written as 0 leave their state unchanged.
- R3: A write to a clear window (enable at 0x080, active at 0x280) clears interrupt 32*W+b for every data bit b written as 1. Bits written as 0 leave their state unchanged.
- R4: A read of either the set window or the clear window of a state type returns the current state bits for that word. Bit b corresponds to interrupt 32*W+b.
- R5: A set-pending write makes the interrupt pending. If the interrupt is in level mode, the write also sets its software-pending latch, so pending survives a later fall of the line.
- R6: A clear-pending write (window 0x180) on a level-mode interrupt clears the software latch and loads pending from the current line value. On an edge-mode interrupt it clears pending whatever the line is.
- R7: In configuration word C, bit 2j+1 selects edge (1) or level (0) for interrupt 16*C+j. A read returns the mode in bit 2j+1 and zero in bit 2j.
- R8: Configuration writes to interrupts 0 to 31 are ignored. These interrupts stay level-triggered.
- R9: A configuration write that selects level mode sets pending to the line value OR the software-pending latch.
- R10: In level mode, a rising line sets pending. A falling line clears pending when the software latch is clear. A bus write in the same cycle takes effect after the line event.
- R11: Interrupt IDs at or beyond NUM_IRQ read zero and ignore writes. Size code 01 or 11, and a word access whose address bits [1:0] are not zero, both read zero and change no state.
- R12: Size code 00 is a byte access. Address bits [1:0] select byte lane L, the write uses data bits [7:0] for state bits 8L to 8L+7, and the read returns that lane in bits [7:0]. Size code 10 is an aligned 32-bit access.
- R13: Read data appears in the cycle after the read strobe, reflects the state before any write in the same cycle, and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 10 | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_size_i | input | 2 | Access size: 00 byte, 10 word |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_line_i | input | NUM_IRQ | Level input line per interrupt |
| enable_o | output | NUM_IRQ | Enable state per interrupt |
| pending_o | output | NUM_IRQ | Pending state per interrupt |
| active_o | output | NUM_IRQ | Active state per interrupt |
| edge_mode_o | output | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |

## Verification
The bench targets several cases where a wrong design gives a visible result:

- **Software latch surviving a line fall.** A design that stores no software latch drops pending when the line falls after a set-pending write.
- **Clear-pending with the line high.** A design that ignores trigger mode on clear either leaves edge interrupts pending or wrongly drops level interrupts whose line is high.
- **Return to level mode.** Switching an edge interrupt whose line is high back to level must revive pending. A design that only stores the mode misses this.
- **Private and out-of-range IDs.** Configuration writes to private IDs, and accesses beyond NUM_IRQ, must leave no trace. Byte lanes and illegal sizes are also tested, because a shifted lane mask corrupts neighbouring interrupts.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int ADDR_W  = 10;
  localparam int BUS_W   = 32;
  localparam int BIT_WW  = 5;   // word index width, one-bit windows
  localparam int CFG_WW  = 6;   // word index width, configuration window

  typedef enum logic [2:0] {
    WIN_SET_EN   = 3'd0,
    WIN_CLR_EN   = 3'd1,
    WIN_SET_PEND = 3'd2,
    WIN_CLR_PEND = 3'd3,
    WIN_SET_ACT  = 3'd4,
    WIN_CLR_ACT  = 3'd5,
    WIN_CFG_LO   = 3'd6,
    WIN_CFG_HI   = 3'd7
  } win_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic set_pend;
    logic clr_pend;
    logic set_act;
    logic clr_act;
    logic cfg_wr;
    logic cfg_edge;
  } cell_cmd_t;

  function automatic logic access_legal(logic [1:0] size, logic [1:0] lane);
    return (size == SZ_BYTE) || ((size == SZ_WORD) && (lane == 2'd0));
  endfunction

  function automatic logic [BUS_W-1:0] lane_mask(logic [1:0] size, logic [1:0] lane);
    if (size == SZ_WORD) return '1;
    return 32'h0000_00FF << {lane, 3'b000};
  endfunction

  function automatic logic [BUS_W-1:0] align_wdata(logic [1:0] size, logic [1:0] lane,
                                                   logic [BUS_W-1:0] wdata);
    if (size == SZ_WORD) return wdata;
    return {24'd0, wdata[7:0]} << {lane, 3'b000};
  endfunction

  function automatic logic [BUS_W-1:0] narrow_rdata(logic [1:0] size, logic [1:0] lane,
                                                    logic [BUS_W-1:0] word);
    if (size == SZ_WORD) return word;
    return (word >> {lane, 3'b000}) & 32'h0000_00FF;
  endfunction

  function automatic logic [BUS_W-1:0] cfg_word(logic [15:0] edges);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) r[2*j+1] = edges[j];
    return r;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              legal_o,
  output win_e              win_o,
  output logic              is_cfg_o,
  output logic [BIT_WW-1:0] bit_word_o,
  output logic [CFG_WW-1:0] cfg_word_o,
  output logic [1:0]        lane_o,
  output logic [BUS_W-1:0]  wd_o,
  output logic [BUS_W-1:0]  mask_o
);

  assign lane_o     = addr_i[1:0];
  assign win_o      = win_e'(addr_i[9:7]);
  assign is_cfg_o   = addr_i[9] & addr_i[8];
  assign bit_word_o = addr_i[6:2];
  assign cfg_word_o = addr_i[7:2];
  assign legal_o    = access_legal(size_i, addr_i[1:0]);
  assign wd_o       = align_wdata(size_i, addr_i[1:0], wdata_i);
  assign mask_o     = lane_mask(size_i, addr_i[1:0]);

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell
  import irq_bank_pkg::*;
#(
  parameter bit FIXED_CFG = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cell_cmd_t cmd_i,
  input  logic      line_i,
  output logic      en_o,
  output logic      pend_o,
  output logic      act_o,
  output logic      edge_o
);

  logic line_q, soft_q, en_q, pend_q, act_q;
  logic pend_d, soft_d;
  logic rise_lvl, fall_lvl, to_level;

  // line events, level mode only
  assign rise_lvl = ~edge_o & line_i & ~line_q;
  assign fall_lvl = ~edge_o & ~line_i & line_q & ~soft_q;
  assign to_level = cmd_i.cfg_wr & ~cmd_i.cfg_edge;

  generate
    if (FIXED_CFG) begin : g_fixed
      assign edge_o = 1'b0;
    end else begin : g_prog
      logic edge_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           edge_q <= 1'b0;
        else if (cmd_i.cfg_wr) edge_q <= cmd_i.cfg_edge;
      end
      assign edge_o = edge_q;
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    soft_d = soft_q;
    if (rise_lvl) pend_d = 1'b1;
    if (fall_lvl) pend_d = 1'b0;
    if (cmd_i.set_pend) begin
      pend_d = 1'b1;
      if (!edge_o) soft_d = 1'b1;
    end
    if (cmd_i.clr_pend) begin
      if (edge_o) begin
        pend_d = 1'b0;
      end else begin
        soft_d = 1'b0;
        pend_d = line_i;
      end
    end
    if (to_level) pend_d = line_i | soft_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      soft_q <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      soft_q <= soft_d;
      pend_q <= pend_d;
      if (cmd_i.set_en)       en_q  <= 1'b1;
      else if (cmd_i.clr_en)  en_q  <= 1'b0;
      if (cmd_i.set_act)      act_q <= 1'b1;
      else if (cmd_i.clr_act) act_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;

endmodule

// File: rtl/irq_read_path.sv
module irq_read_path
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              legal_i,
  input  win_e              win_i,
  input  logic              is_cfg_i,
  input  logic [BIT_WW-1:0] bit_word_i,
  input  logic [CFG_WW-1:0] cfg_word_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        size_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] act_i,
  input  logic [NUM_IRQ-1:0] edge_i,
  output logic [BUS_W-1:0]  rdata_o
);

  localparam int NW  = NUM_IRQ / 32;
  localparam int NCW = NUM_IRQ / 16;

  logic [NUM_IRQ-1:0] bit_src;
  logic [BUS_W-1:0]   word_sel, cfg_sel, raw, rd_next;

  always_comb begin
    case (win_i)
      WIN_SET_PEND, WIN_CLR_PEND: bit_src = pend_i;
      WIN_SET_ACT,  WIN_CLR_ACT:  bit_src = act_i;
      default:                    bit_src = en_i;
    endcase
    word_sel = '0;
    for (int w = 0; w < NW; w++)
      if (bit_word_i == BIT_WW'(w)) word_sel = bit_src[w*32 +: 32];
    cfg_sel = '0;
    for (int w = 0; w < NCW; w++)
      if (cfg_word_i == CFG_WW'(w)) cfg_sel = cfg_word(edge_i[w*16 +: 16]);
    raw     = is_cfg_i ? cfg_sel : word_sel;
    rd_next = legal_i ? narrow_rdata(size_i, lane_i, raw) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_next;
  end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [9:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  input  logic [1:0]         bus_size_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_line_i,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [NUM_IRQ-1:0] edge_mode_o
);

  logic              legal, is_cfg, wr_accept;
  win_e              win;
  logic [BIT_WW-1:0] bit_word;
  logic [CFG_WW-1:0] cfg_word_idx;
  logic [1:0]        lane;
  logic [BUS_W-1:0]  wd, mask;
  logic              unused_mask;

  irq_bus_decode u_dec (
    .addr_i     (bus_addr_i),
    .size_i     (bus_size_i),
    .wdata_i    (bus_wdata_i),
    .legal_o    (legal),
    .win_o      (win),
    .is_cfg_o   (is_cfg),
    .bit_word_o (bit_word),
    .cfg_word_o (cfg_word_idx),
    .lane_o     (lane),
    .wd_o       (wd),
    .mask_o     (mask)
  );

  // accepted write, brought out for the checker
  assign wr_accept   = bus_wr_i & legal;
  assign unused_mask = ^mask;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam int BW = i / 32;
      localparam int BB = i % 32;
      localparam int CW = i / 16;
      localparam int CB = 2 * (i % 16) + 1;
      localparam bit PRIV = (i < NUM_PRIV);
      logic      bit_hit, cfg_hit;
      cell_cmd_t cmd;

      assign bit_hit = wr_accept & ~is_cfg & (bit_word == BIT_WW'(BW)) & wd[BB];
      assign cfg_hit = wr_accept & is_cfg & (cfg_word_idx == CFG_WW'(CW)) & mask[CB];

      always_comb begin
        cmd          = '0;
        cmd.set_en   = bit_hit & (win == WIN_SET_EN);
        cmd.clr_en   = bit_hit & (win == WIN_CLR_EN);
        cmd.set_pend = bit_hit & (win == WIN_SET_PEND);
        cmd.clr_pend = bit_hit & (win == WIN_CLR_PEND);
        cmd.set_act  = bit_hit & (win == WIN_SET_ACT);
        cmd.clr_act  = bit_hit & (win == WIN_CLR_ACT);
        cmd.cfg_wr   = cfg_hit & ~PRIV;
        cmd.cfg_edge = wd[CB];
      end

      irq_state_cell #(.FIXED_CFG(PRIV)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (cmd),
        .line_i (irq_line_i[i]),
        .en_o   (enable_o[i]),
        .pend_o (pending_o[i]),
        .act_o  (active_o[i]),
        .edge_o (edge_mode_o[i])
      );
    end
  endgenerate

  irq_read_path #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (bus_rd_i),
    .legal_i    (legal),
    .win_i      (win),
    .is_cfg_i   (is_cfg),
    .bit_word_i (bit_word),
    .cfg_word_i (cfg_word_idx),
    .lane_i     (lane),
    .size_i     (bus_size_i),
    .en_i       (enable_o),
    .pend_i     (pending_o),
    .act_i      (active_o),
    .edge_i     (edge_mode_o),
    .rdata_o    (bus_rdata_o)
  );

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_rd_i,
  input logic               bus_wr_i,
  input logic [31:0]        bus_rdata_o,
  input logic [NUM_IRQ-1:0] irq_line_i,
  input logic [NUM_IRQ-1:0] enable_o,
  input logic [NUM_IRQ-1:0] pending_o,
  input logic [NUM_IRQ-1:0] active_o,
  input logic [NUM_IRQ-1:0] edge_mode_o,
  input logic               wr_accept
);

  logic [NUM_IRQ-1:0] line_prev, rise_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev <= '0;
    else         line_prev <= irq_line_i;
  end

  assign rise_lvl = irq_line_i & ~line_prev & ~edge_mode_o;

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (enable_o == '0 && pending_o == '0 && active_o == '0 &&
                 edge_mode_o == '0 && bus_rdata_o == '0));

  a_r8_private_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_o[31:0] == 32'd0);

  a_r10_level_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_lvl != '0) |=> ((pending_o & $past(rise_lvl)) == $past(rise_lvl)));

  a_r11_illegal_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !wr_accept) |=> ($stable(enable_o) && $stable(active_o) && $stable(edge_mode_o)));

  a_r2_quiet_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_accept |=> ($stable(enable_o) && $stable(active_o) && $stable(edge_mode_o)));

  a_r13_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_line_i  (irq_line_i),
  .enable_o    (enable_o),
  .pending_o   (pending_o),
  .active_o    (active_o),
  .edge_mode_o (edge_mode_o),
  .wr_accept   (wr_accept)
);

// File: tb/irq_state_bank_bench.sv
module irq_state_bank_bench;

  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [1:0]    size = 2'b10;
  logic          rd = 1'b0, wr = 1'b0;
  logic [31:0]   rdata;
  logic [N-1:0]  line = '0;
  logic [N-1:0]  en_o, pend_o, act_o, edge_o;

  logic [N-1:0]  m_en = '0, m_pend = '0, m_act = '0, m_edge = '0, m_soft = '0, m_lq = '0;
  logic [31:0]   exp_rd = '0;
  int            errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_state_bank #(.NUM_IRQ(N)) u_irq_state_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_size_i(size), .bus_rd_i(rd), .bus_wr_i(wr), .bus_rdata_o(rdata),
    .irq_line_i(line), .enable_o(en_o), .pending_o(pend_o),
    .active_o(act_o), .edge_mode_o(edge_o)
  );

  function automatic bit ok_access(logic [9:0] a, logic [1:0] s);
    return s == 2'b00 || (s == 2'b10 && a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a, logic [1:0] s);
    logic [31:0] v = '0;
    int sel = a[9:7];
    if (!ok_access(a, s)) return 32'd0;
    for (int b = 0; b < 32; b++) begin
      if (sel >= 6) begin
        int id = int'(a[7:2]) * 16 + b / 2;
        if (b % 2 == 1 && id < N) v[b] = m_edge[id];
      end else begin
        int id = int'(a[6:2]) * 32 + b;
        if (id < N) v[b] = (sel < 2) ? m_en[id] : (sel < 4) ? m_pend[id] : m_act[id];
      end
    end
    if (s == 2'b00) v = (v >> (8 * a[1:0])) & 32'hFF;
    return v;
  endfunction

  task automatic model_clock(logic w, logic r, logic [9:0] a, logic [31:0] d,
                             logic [1:0] s, logic [N-1:0] ln);
    logic [31:0] dm, mk;
    int sel = a[9:7];
    if (r) exp_rd = m_read(a, s);
    mk = (s == 2'b10) ? 32'hFFFF_FFFF : (32'hFF << (8 * a[1:0]));
    dm = (s == 2'b10) ? d : ((d & 32'hFF) << (8 * a[1:0]));
    for (int i = 0; i < N; i++) begin
      logic lvl = !m_edge[i];
      logic np = m_pend[i], ns = m_soft[i];
      if (lvl && ln[i] && !m_lq[i]) np = 1'b1;
      if (lvl && !ln[i] && m_lq[i] && !ns) np = 1'b0;
      if (w && ok_access(a, s)) begin
        if (sel < 6) begin
          if (i / 32 == int'(a[6:2]) && dm[i % 32]) begin
            case (sel)
              0: m_en[i] = 1'b1;
              1: m_en[i] = 1'b0;
              2: begin np = 1'b1; if (lvl) ns = 1'b1; end
              3: if (lvl) begin ns = 1'b0; np = ln[i]; end else np = 1'b0;
              4: m_act[i] = 1'b1;
              default: m_act[i] = 1'b0;
            endcase
          end
        end else begin
          int pb = 2 * (i % 16) + 1;
          if (i >= 32 && i / 16 == int'(a[7:2]) && mk[pb]) begin
            m_edge[i] = dm[pb];
            if (!dm[pb]) np = ln[i] | ns;
          end
        end
      end
      m_pend[i] = np;
      m_soft[i] = ns;
    end
    m_lq = ln;
  endtask

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " enable"}, en_o, m_en);
    chk({tag, " pending"}, pend_o, m_pend);
    chk({tag, " active"}, act_o, m_act);
    chk({tag, " mode"}, edge_o, m_edge);
    chk({tag, " rdata"}, {32'd0, rdata}, {32'd0, exp_rd});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic w, logic r, logic [9:0] a, logic [31:0] d,
                      logic [1:0] s, logic [N-1:0] ln, string tag);
    wr = w; rd = r; addr = a; wdata = d; size = s; line = ln;
    @(posedge clk);
    model_clock(w, r, a, d, s, ln);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr32(logic [9:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b0, a, d, 2'b10, line, tag);
  endtask

  task automatic rd32(logic [9:0] a, string tag);
    step(1'b0, 1'b1, a, 32'd0, 2'b10, line, tag);
  endtask

  task automatic set_line(int id, logic v, string tag);
    logic [N-1:0] ln = line;
    ln[id] = v;
    step(1'b0, 1'b0, 10'd0, 32'd0, 2'b10, ln, tag);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    rd32(10'h180, "R1 after reset");

    wr32(10'h000, 32'h0000_00F0, "R2 set enable");
    wr32(10'h000, 32'h0000_0001, "R2 set enable keeps others");
    chk("R2 enable value", en_o, 64'hF1);
    rd32(10'h000, "R4 read set window");
    chk("R4 set window", {32'd0, rdata}, 64'hF1);
    rd32(10'h080, "R4 read clear window");
    chk("R4 clear window", {32'd0, rdata}, 64'hF1);
    wr32(10'h080, 32'h0000_0030, "R3 clear enable");
    chk("R3 enable value", en_o, 64'hC1);
    wr32(10'h204, 32'h8000_0001, "R2 set active");
    wr32(10'h284, 32'h0000_0001, "R3 clear active");
    chk("R3 active value", act_o, 64'h8000_0000_0000_0000);

    wr32(10'h308, 32'h0003_0000, "R7 config edge");
    chk("R7 mode of 40", edge_o, 64'h0000_0100_0000_0000);
    rd32(10'h308, "R7 config read");
    chk("R7 lower bit zero", {32'd0, rdata}, 64'h0002_0000);
    wr32(10'h300, 32'hFFFF_FFFF, "R8 private config");
    rd32(10'h300, "R8 private read");
    chk("R8 private mode", {32'd0, rdata}, 64'd0);

    wr32(10'h104, 32'h0000_0002, "R5 set pending level");
    set_line(33, 1'b1, "R10 rise");
    set_line(33, 1'b0, "R5 fall keeps latch");
    chk("R5 latch holds pending", {63'd0, pend_o[33]}, 64'd1);
    set_line(33, 1'b1, "R10 rise again");
    wr32(10'h184, 32'h0000_0002, "R6 clear level line high");
    chk("R6 level reload", {63'd0, pend_o[33]}, 64'd1);
    set_line(33, 1'b0, "R10 fall");
    chk("R10 fall clears", {63'd0, pend_o[33]}, 64'd0);

    wr32(10'h104, 32'h0000_0100, "R5 set pending edge");
    set_line(40, 1'b1, "R6 edge line high");
    wr32(10'h184, 32'h0000_0100, "R6 clear edge");
    chk("R6 edge cleared", {63'd0, pend_o[40]}, 64'd0);
    wr32(10'h308, 32'h0000_0000, "R9 back to level");
    chk("R9 revived", {63'd0, pend_o[40]}, 64'd1);
    set_line(50, 1'b1, "R10 level rise 50");
    chk("R10 rise sets", {63'd0, pend_o[50]}, 64'd1);

    wr32(10'h008, 32'hFFFF_FFFF, "R11 beyond range write");
    rd32(10'h008, "R11 beyond range read");
    chk("R11 beyond range", {32'd0, rdata}, 64'd0);
    wr32(10'h310, 32'hFFFF_FFFF, "R11 beyond range config");
    step(1'b1, 1'b1, 10'h000, 32'hFFFF_FFFF, 2'b01, line, "R11 odd size");
    step(1'b1, 1'b1, 10'h002, 32'hFFFF_FFFF, 2'b10, line, "R11 misaligned");
    chk("R11 misaligned read", {32'd0, rdata}, 64'd0);

    step(1'b1, 1'b0, 10'h005, 32'hFFFF_FFA5, 2'b00, line, "R12 byte write");
    chk("R12 byte lane", en_o, 64'h0000_A500_0000_00C1);
    step(1'b0, 1'b1, 10'h005, 32'd0, 2'b00, line, "R12 byte read");
    chk("R12 byte read value", {32'd0, rdata}, 64'hA5);
    step(1'b1, 1'b0, 10'h000, 32'hFFFF_FFFF, 2'b10, line, "R13 hold");
    chk("R13 held rdata", {32'd0, rdata}, 64'hA5);

    for (int k = 0; k < 3000; k++) begin
      logic [9:0]   a;
      logic [1:0]   s;
      logic [N-1:0] ln;
      int sel = $urandom % 8;
      logic [1:0] lane = 2'($urandom % 4);
      s = ($urandom % 10 == 0) ? 2'b01 : (($urandom % 2) ? 2'b10 : 2'b00);
      if (s == 2'b10 && ($urandom % 8 != 0)) lane = 2'd0;
      if (sel < 6) a = 10'(sel << 7) | 10'(($urandom % 3) << 2) | 10'(lane);
      else         a = 10'h300 | 10'(($urandom % 5) << 2) | 10'(lane);
      ln = line ^ {($urandom & $urandom & $urandom), ($urandom & $urandom & $urandom)};
      step(1'($urandom % 2), 1'($urandom % 2), a, $urandom, s, ln,
           "R2 R3 R4 R5 R6 R7 R9 R10 R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule